// File: doc/BRIEF.md
# Double-Banked Crosspoint Map Store

This block keeps the routing map of a crosspoint switch: one source index for every destination port. The map is held in two banks. One bank is active and feeds a scanner, which walks the destinations in a loop and puts out one `{destination, source, valid}` word per clock toward the crosspoint and port-direction logic. A host edits the other, inactive bank one entry at a time. When an edit set is complete, the host raises `commit`. The controller then swaps the bank roles at the next scan-pass boundary. At that same edge it copies the new active map into the new inactive bank, so the next edit starts from the current routing. It also mirrors the new active map into a retained backup bank.

The backup bank is cleared only by the power-on reset `por_n`. A warm reset `rst_n` clears both working banks and starts a restore walk. The walk copies the backup into both banks one entry per clock, and while it runs `busy` is high. Only after the walk does the scanner start at destination 0. The switch therefore comes back with the routing it had before the reset.

The controller is a two-state machine. In `ST_RESTORE` the restore index advances once per clock, and the transition `restore_done` (index at the last destination) moves the machine to `ST_SCAN`. In `ST_SCAN` the machine stays until reset, and within it the events `swap` (pending commit at end of pass) and `overrun` (commit while a commit is pending) take place.

Top module: `xmap_store`

## Requirements
- R1: From the release of `rst_n`, `busy` is high and `scan_valid` low for exactly NUM_DEST clocks. In the next cycle `scan_valid` rises with `scan_dest` = 0 and `busy` low.
- R2: The restore walk loads every entry of both working banks from the backup bank, so a commit with no writes after restore leaves the scanned map unchanged.
- R3: A host write (`wr_en`, `wr_dest`, `wr_src`) outside restore changes only the inactive bank. The scanned sources do not change until a swap.
- R4: A pending commit swaps banks only on the clock where `scan_dest` = NUM_DEST-1. `bank_sel` toggles (0 = bank A active, 1 = bank B active), and the next word, at `scan_dest` = 0, comes from the new bank.
- R5: On a swap, the new inactive bank receives a full copy of the new active bank, so that entries the next edit does not touch keep their current routing.
- R6: A host write in the swap cycle lands in the new inactive bank only. Neither the new active bank nor the backup bank takes it.
- R7: At every swap the backup bank takes the new active map. `por_n` low clears the backup bank to all-zero sources. `rst_n` alone leaves it intact.
- R8: While `busy` is high, host writes and commits have no effect on any bank, on `bank_sel`, or on `overrun`.
- R9: A commit while a commit is already pending (and not in the swap cycle) produces exactly one swap, and `overrun` pulses high for the one cycle after that commit.
- R10: While scanning, `scan_valid` is high and `scan_dest` steps 0, 1, …, NUM_DEST-1, 0, … by one every clock. `scan_src` is the active bank's entry for `scan_dest`.
- R11: A commit in the swap cycle arms a new pending commit for the following pass and raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low, asynchronous; starts the restore walk |
| por_n | input | 1 | Power-on reset, active low; clears the backup bank |
| wr_en | input | 1 | Host write strobe for one inactive-bank entry |
| wr_dest | input | DEST_W | Destination index written |
| wr_src | input | SRC_W | Source index stored for that destination |
| commit | input | 1 | Request to swap bank roles at the next pass boundary |
| busy | output | 1 | Restore walk in progress |
| bank_sel | output | 1 | Active bank: 0 = A, 1 = B |
| overrun | output | 1 | One-cycle pulse: commit arrived while one was pending |
| scan_valid | output | 1 | Scanner word valid |
| scan_dest | output | DEST_W | Scanner destination index |
| scan_src | output | SRC_W | Active source index for scan_dest |

## Verification
Two kinds of same-cycle collision are provoked.

- **Write in the swap cycle.** The swap (bank flip, copy and mirror) falls in the same cycle as a host write. The bench follows its reference model's scan position, and drives a write exactly on the clock where the last destination is scanned with a commit pending.
- **Commit in the swap cycle.** The swap falls in the same cycle as a fresh commit. The bench drives a commit on that same clock.

Each case is judged by comparing every scanned word, `bank_sel` and `overrun` with the model over the following passes. A later commit exposes what reached the inactive bank, and a warm reset exposes what reached the backup.

// File: rtl/xmap_pkg.sv
`timescale 1ns/1ps
package xmap_pkg;

    typedef enum logic {
        ST_RESTORE = 1'b0,
        ST_SCAN    = 1'b1
    } xmap_state_e;

endpackage

// File: rtl/xmap_ctrl.sv
`timescale 1ns/1ps
module xmap_ctrl
    import xmap_pkg::*;
#(
    parameter int NUM_DEST = 32,
    localparam int DEST_W  = $clog2(NUM_DEST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              eop,
    output logic              busy,
    output logic              scan_en,
    output logic              swap_now,
    output logic              bank_sel,
    output logic              overrun,
    output logic [DEST_W-1:0] ridx
);

    localparam logic [DEST_W-1:0] LAST = DEST_W'(NUM_DEST - 1);

    xmap_state_e       st_q, st_d;
    logic              pend_q;
    logic [DEST_W-1:0] ridx_q;

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESTORE: if (ridx_q == LAST) st_d = ST_SCAN;  // restore_done
            ST_SCAN:    st_d = ST_SCAN;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        scan_en  = 1'b0;
        swap_now = 1'b0;
        unique case (st_q)
            ST_RESTORE: busy = 1'b1;
            ST_SCAN: begin
                scan_en  = 1'b1;
                swap_now = pend_q & eop;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_RESTORE;
            ridx_q   <= '0;
            pend_q   <= 1'b0;
            bank_sel <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            st_q   <= st_d;
            ridx_q <= busy ? ridx_q + 1'b1 : '0;
            if (busy) begin
                overrun <= 1'b0;
            end else begin
                overrun <= commit & pend_q & ~swap_now;
                if (swap_now) bank_sel <= ~bank_sel;
                if (commit)        pend_q <= 1'b1;
                else if (swap_now) pend_q <= 1'b0;
            end
        end
    end

    assign ridx = ridx_q;

    AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !eop |=> $stable(bank_sel));                                   // R4
    AST_BUSY_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_sel));                                   // R8
    AST_BUSY_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && commit) |=> !overrun);                                // R8
    AST_OVERRUN_KEEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> pend_q);                                           // R9

endmodule

// File: rtl/xmap_scan.sv
`timescale 1ns/1ps
module xmap_scan #(
    parameter int NUM_DEST = 32,
    localparam int DEST_W  = $clog2(NUM_DEST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [DEST_W-1:0] idx,
    output logic              eop
);

    localparam logic [DEST_W-1:0] LAST = DEST_W'(NUM_DEST - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (en)  idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    assign eop = en && (idx == LAST);

    AST_SCAN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (idx == '0));                                    // R1

endmodule

// File: rtl/xmap_store.sv
`timescale 1ns/1ps
module xmap_store #(
    parameter int NUM_DEST = 32,
    parameter int SRC_W    = 5,
    localparam int DEST_W  = $clog2(NUM_DEST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [DEST_W-1:0] wr_dest,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic              commit,
    output logic              busy,
    output logic              bank_sel,
    output logic              overrun,
    output logic              scan_valid,
    output logic [DEST_W-1:0] scan_dest,
    output logic [SRC_W-1:0]  scan_src
);

    logic              scan_en, swap_now, eop;
    logic [DEST_W-1:0] ridx;
    logic [SRC_W-1:0]  a_arr [NUM_DEST];
    logic [SRC_W-1:0]  b_arr [NUM_DEST];

    xmap_ctrl #(.NUM_DEST(NUM_DEST)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .eop      (eop),
        .busy     (busy),
        .scan_en  (scan_en),
        .swap_now (swap_now),
        .bank_sel (bank_sel),
        .overrun  (overrun),
        .ridx     (ridx)
    );

    xmap_scan #(.NUM_DEST(NUM_DEST)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (scan_en),
        .idx   (scan_dest),
        .eop   (eop)
    );

    for (genvar i = 0; i < NUM_DEST; i++) begin : g_ent
        logic [SRC_W-1:0] a_q, b_q, k_q;
        logic             hit, rload;

        assign hit   = wr_en && !busy && (wr_dest == DEST_W'(i));
        assign rload = busy && (ridx == DEST_W'(i));

        // working banks
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else if (rload) begin
                a_q <= k_q;
                b_q <= k_q;
            end else if (swap_now) begin
                if (!bank_sel) a_q <= hit ? wr_src : b_q;
                else           b_q <= hit ? wr_src : a_q;
            end else if (hit) begin
                if (!bank_sel) b_q <= wr_src;
                else           a_q <= wr_src;
            end
        end

        // retained backup mirror
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)        k_q <= '0;
            else if (swap_now) k_q <= bank_sel ? a_q : b_q;
        end

        assign a_arr[i] = a_q;
        assign b_arr[i] = b_q;
    end

    assign scan_valid = scan_en;
    assign scan_src   = bank_sel ? b_arr[scan_dest] : a_arr[scan_dest];

    AST_FLIP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel) |-> (scan_dest == '0));                     // R4
    AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !scan_valid);                                         // R1

endmodule

// File: tb/sim_xmap_store.sv
`timescale 1ns/1ps
module sim_xmap_store;

    localparam int N  = 32;
    localparam int SW = 5;
    localparam int DW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, por_n = 1'b0;
    logic          wr_en = 1'b0, commit = 1'b0;
    logic [DW-1:0] wr_dest = '0;
    logic [SW-1:0] wr_src = '0;
    logic          busy, bank_sel, overrun, scan_valid;
    logic [DW-1:0] scan_dest;
    logic [SW-1:0] scan_src;

    always #10 clk = ~clk;   // 50 MHz

    xmap_store #(.NUM_DEST(N), .SRC_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .wr_dest(wr_dest), .wr_src(wr_src), .commit(commit),
        .busy(busy), .bank_sel(bank_sel), .overrun(overrun),
        .scan_valid(scan_valid), .scan_dest(scan_dest), .scan_src(scan_src)
    );

    // reference model
    int ma[N], mb[N], mk[N], tmp[N];
    int m_sel, m_pend, m_rest, m_ridx, m_sidx, m_ovr, m_swap;

    always @(posedge clk) begin
        if (!por_n) for (int i = 0; i < N; i++) mk[i] = 0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin ma[i] = 0; mb[i] = 0; end
            m_sel = 0; m_pend = 0; m_rest = 1; m_ridx = 0; m_sidx = 0; m_ovr = 0;
        end else if (m_rest) begin
            ma[m_ridx] = mk[m_ridx];
            mb[m_ridx] = mk[m_ridx];
            if (m_ridx == N - 1) m_rest = 0;
            m_ridx = m_ridx + 1;
            m_ovr = 0;
        end else begin
            m_swap = (m_pend && m_sidx == N - 1) ? 1 : 0;
            m_ovr  = (commit && m_pend && !m_swap) ? 1 : 0;
            if (m_swap) begin
                for (int i = 0; i < N; i++) begin
                    tmp[i] = m_sel ? ma[i] : mb[i];
                    mk[i]  = tmp[i];
                    if (m_sel) mb[i] = tmp[i]; else ma[i] = tmp[i];
                end
                if (wr_en) begin
                    if (m_sel) mb[wr_dest] = wr_src; else ma[wr_dest] = wr_src;
                end
                m_sel = 1 - m_sel;
            end else if (wr_en) begin
                if (m_sel) ma[wr_dest] = wr_src; else mb[wr_dest] = wr_src;
            end
            if (commit) m_pend = 1;
            else if (m_swap) m_pend = 0;
            m_sidx = (m_sidx + 1) % N;
        end
    end

    int    nchk = 0, nerr = 0;
    bit    done = 0;
    string tag = "R1";

    task automatic chk(string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("busy (R1)", int'(busy), m_rest);
            chk("scan_valid (R10)", int'(scan_valid), 1 - m_rest);
            chk("bank_sel (R4)", int'(bank_sel), m_sel);
            chk("overrun (R9)", int'(overrun), m_ovr);
            if (!m_rest) begin
                chk("scan_dest (R10)", int'(scan_dest), m_sidx);
                chk("scan_src (R3)", int'(scan_src), m_sel ? mb[m_sidx] : ma[m_sidx]);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int d, int s);
        wr_en = 1'b1; wr_dest = DW'(d); wr_src = SW'(s);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmt();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic to_swap_cycle();
        while (!(m_pend && m_sidx == N - 1)) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL %s watchdog: actual hung expected finished", tag);
        finish_run();
    end

    initial begin
        // R1 / R7: power-on, everything zero, restore walk
        tag = "R1";
        cyc(3);
        por_n = 1'b1; rst_n = 1'b1;
        cyc(N + 40);

        // R3: writes only to inactive bank
        tag = "R3";
        wr(3, 7); wr(31, 1); wr(0, 30);
        cyc(2 * N);

        // R4: commit mid-pass, swap at boundary
        tag = "R4";
        cyc(5);
        cmt();
        cyc(2 * N + 4);

        // R5: partial edit starts from current map
        tag = "R5";
        wr(3, 9);
        cmt();
        cyc(2 * N + 4);

        // R6: write in the swap cycle
        tag = "R6";
        wr(10, 12);
        cmt();
        to_swap_cycle();
        wr(5, 21);
        cyc(N);
        cmt();
        cyc(2 * N + 4);

        // R11: commit in the swap cycle
        tag = "R11";
        wr(7, 17);
        cmt();
        to_swap_cycle();
        cmt();
        cyc(3 * N + 4);

        // R9: commit while pending
        tag = "R9";
        wr(20, 4);
        cyc(3);
        cmt();
        cyc(2);
        cmt();
        cyc(3 * N + 4);

        // R7 / R8: warm reset restores backup; busy ignores host
        tag = "R8";
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        wr(3, 2); wr(8, 8);
        cmt();
        cyc(N + 8);

        // R2: commit without writes keeps the restored map
        tag = "R2";
        cmt();
        cyc(3 * N + 4);

        // R7: power-on reset clears backup
        tag = "R7";
        @(negedge clk);
        por_n = 1'b0; rst_n = 1'b0;
        cyc(2);
        por_n = 1'b1; rst_n = 1'b1;
        cyc(2 * N + 8);

        finish_run();
    end

endmodule